// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's control path and performs the state change that enters a handler. In the cycle a synchronous exception is flagged, or while an external interrupt request is raised, it picks one event to take. It then loads all of the following together on one clock edge: the new program counter, the updated status word, the saved status, PC and stack-pointer copies, and the event code registers.

An exception always wins over an interrupt. When the status word blocks events, an exception is turned into a reset, and an interrupt is held off unless the core is sleeping. The block shows the interrupt controller the current mask level and receives a vector back, which may be marked as absent. After each entry the block raises a one-cycle completion pulse. The core uses that pulse to clear its sleep state and its delay-slot flags.

Top module: `exc_entry_top`

## Requirements
- R1: When `exc_valid` and `irq_req` are high in the same cycle, the exception is taken. `expevt_out` gets the exception code and `intevt_out` keeps its value.
- R2: If status bit 28 (block) is set, an exception with any code other than 0x1E0 is taken as code 0x000. Code 0x1E0 passes through unchanged.
- R3: If status bit 28 is set and `in_sleep` is low, an interrupt request causes no entry. If `in_sleep` is high, the interrupt is taken.
- R4: On entry, `ssr_out` gets `sr_in`, `spc_out` gets `pc_in` and `sgr_out` gets `r15_in`. `sr_out` equals `sr_in` with bits 30, 29 and 28 set, apart from the changes made by R6.
- R5: With `in_dslot` high at entry, `spc_out` is `pc_in - 2`.
- R6: Exception codes 0x000, 0x020 and 0x140 clear status bit 15, set status bits 7:4 to 0xF and load `pc_out` with 0xA0000000.
- R7: Exception codes 0x040 and 0x060 load `pc_out` with `vbr_in + 0x400`.
- R8: Code 0x160 adds 2 to the saved PC, on top of any R5 adjustment. Every exception not covered by R6 or R7 loads `pc_out` with `vbr_in + 0x100`. Every exception entry writes its final code to `expevt_out`.
- R9: `irq_level` equals status bits 7:4. An interrupt with `irq_vec_valid` low causes no entry. Otherwise `intevt_out` gets `irq_vec`, `pc_out` gets `vbr_in + 0x600`, and `expevt_out` keeps its value.
- R10: `done` is high for exactly the one cycle after an entry edge. All output registers change on that same edge.
- R11: In a cycle with no exception and no interrupt that is taken, `done` stays low and no output register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Synchronous exception flagged this cycle |
| exc_code | input | 12 | Code of the flagged exception |
| irq_req | input | 1 | External interrupt request |
| in_sleep | input | 1 | Core is in sleep state |
| in_dslot | input | 1 | Current instruction sits in a delay slot |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| r15_in | input | 32 | Current stack register value |
| vbr_in | input | 32 | Vector base |
| irq_level | output | 4 | Mask level shown to the interrupt controller |
| irq_vec_valid | input | 1 | Controller has an unmasked vector |
| irq_vec | input | 12 | Vector code from the controller |
| done | output | 1 | One-cycle pulse after an entry |
| pc_out | output | 32 | Handler program counter |
| sr_out | output | 32 | Status word after entry |
| ssr_out | output | 32 | Saved status word |
| spc_out | output | 32 | Saved program counter |
| sgr_out | output | 32 | Saved stack register |
| expevt_out | output | 12 | Last exception code |
| intevt_out | output | 12 | Last interrupt vector |

## Verification
The properties assume that `exc_valid` is a single-cycle event. They also assume that the core inputs `sr_in`, `pc_in`, `vbr_in` and the vector inputs already hold settled values in the cycle the event is flagged. The bench drives each event for exactly one cycle on the falling edge, with all context inputs already set. It then drops the request lines before the next edge, so no event is taken twice. The checks for "no entry" compare the registered outputs against the values left by the scenario just before.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    parameter int unsigned XLEN   = 32;
    parameter int unsigned CODE_W = 12;
    parameter int unsigned MASK_W = 4;

    localparam int SR_MD = 30;
    localparam int SR_RB = 29;
    localparam int SR_BL = 28;
    localparam int SR_FD = 15;
    localparam int SR_IM = 4;

    localparam logic [CODE_W-1:0] C_RESET   = 12'h000;
    localparam logic [CODE_W-1:0] C_MANRST  = 12'h020;
    localparam logic [CODE_W-1:0] C_MULTI   = 12'h140;
    localparam logic [CODE_W-1:0] C_TLBR    = 12'h040;
    localparam logic [CODE_W-1:0] C_TLBW    = 12'h060;
    localparam logic [CODE_W-1:0] C_TRAP    = 12'h160;
    localparam logic [CODE_W-1:0] C_UBREAK  = 12'h1E0;

    typedef enum logic [1:0] {ENT_NONE, ENT_EXC, ENT_IRQ} ent_kind_e;
    typedef enum logic [1:0] {TGT_RESET, TGT_TLB, TGT_GEN, TGT_IRQ} tgt_e;

    typedef struct packed {
        ent_kind_e         kind;
        logic [CODE_W-1:0] code;
    } ent_dec_t;

    function automatic tgt_e classify(input ent_dec_t d);
        if (d.kind == ENT_IRQ) return TGT_IRQ;
        if (d.code == C_RESET || d.code == C_MANRST || d.code == C_MULTI) return TGT_RESET;
        if (d.code == C_TLBR || d.code == C_TLBW) return TGT_TLB;
        return TGT_GEN;
    endfunction
endpackage

// File: rtl/exc_entry_arbiter.sv
module exc_entry_arbiter
    import exc_entry_pkg::*;
(
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              in_sleep,
    input  logic              blocked,
    input  logic              vec_valid,
    input  logic [CODE_W-1:0] vec,
    output ent_dec_t          dec
);
    always_comb begin
        dec.kind = ENT_NONE;
        dec.code = '0;
        if (exc_valid) begin
            dec.kind = ENT_EXC;
            dec.code = (blocked && exc_code != C_UBREAK) ? C_RESET : exc_code;
        end else if (irq_req && (!blocked || in_sleep) && vec_valid) begin
            dec.kind = ENT_IRQ;
            dec.code = vec;
        end
    end
endmodule

// File: rtl/exc_entry_target.sv
module exc_entry_target
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
    parameter logic [XLEN-1:0] OFF_GEN  = 32'h0000_0100,
    parameter logic [XLEN-1:0] OFF_TLB  = 32'h0000_0400,
    parameter logic [XLEN-1:0] OFF_IRQ  = 32'h0000_0600,
    parameter int unsigned     INSN_B   = 2
) (
    input  ent_dec_t          dec,
    input  logic [XLEN-1:0]   sr,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   vbr,
    input  logic              in_dslot,
    output logic [XLEN-1:0]   nxt_pc,
    output logic [XLEN-1:0]   nxt_sr,
    output logic [XLEN-1:0]   nxt_spc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_B);
    tgt_e tgt;

    always_comb begin
        tgt = classify(dec);
        nxt_sr = sr;
        nxt_sr[SR_BL] = 1'b1;
        nxt_sr[SR_MD] = 1'b1;
        nxt_sr[SR_RB] = 1'b1;
        nxt_spc = pc;
        if (in_dslot) nxt_spc = nxt_spc - STEP;
        if (dec.kind == ENT_EXC && dec.code == C_TRAP) nxt_spc = nxt_spc + STEP;
        unique case (tgt)
            TGT_RESET: begin
                nxt_pc = RESET_PC;
                nxt_sr[SR_FD] = 1'b0;
                nxt_sr[SR_IM +: MASK_W] = '1;
            end
            TGT_TLB:  nxt_pc = vbr + OFF_TLB;
            TGT_IRQ:  nxt_pc = vbr + OFF_IRQ;
            default:  nxt_pc = vbr + OFF_GEN;
        endcase
    end
endmodule

// File: rtl/exc_entry_top.sv
module exc_entry_top
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              in_sleep,
    input  logic              in_dslot,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    output logic [MASK_W-1:0] irq_level,
    input  logic              irq_vec_valid,
    input  logic [CODE_W-1:0] irq_vec,
    output logic              done,
    output logic [XLEN-1:0]   pc_out,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   ssr_out,
    output logic [XLEN-1:0]   spc_out,
    output logic [XLEN-1:0]   sgr_out,
    output logic [CODE_W-1:0] expevt_out,
    output logic [CODE_W-1:0] intevt_out
);
    ent_dec_t        dec;
    logic [XLEN-1:0] nxt_pc, nxt_sr, nxt_spc;

    assign irq_level = sr_in[SR_IM +: MASK_W];

    exc_entry_arbiter u_arb (
        .exc_valid (exc_valid),
        .exc_code  (exc_code),
        .irq_req   (irq_req),
        .in_sleep  (in_sleep),
        .blocked   (sr_in[SR_BL]),
        .vec_valid (irq_vec_valid),
        .vec       (irq_vec),
        .dec       (dec)
    );

    exc_entry_target #(.RESET_PC(RESET_PC)) u_tgt (
        .dec      (dec),
        .sr       (sr_in),
        .pc       (pc_in),
        .vbr      (vbr_in),
        .in_dslot (in_dslot),
        .nxt_pc   (nxt_pc),
        .nxt_sr   (nxt_sr),
        .nxt_spc  (nxt_spc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            pc_out     <= '0;
            sr_out     <= '0;
            ssr_out    <= '0;
            spc_out    <= '0;
            sgr_out    <= '0;
            expevt_out <= '0;
            intevt_out <= '0;
        end else begin
            done <= (dec.kind != ENT_NONE);
            if (dec.kind != ENT_NONE) begin
                pc_out  <= nxt_pc;
                sr_out  <= nxt_sr;
                ssr_out <= sr_in;
                spc_out <= nxt_spc;
                sgr_out <= r15_in;
            end
            if (dec.kind == ENT_EXC) expevt_out <= dec.code;
            if (dec.kind == ENT_IRQ) intevt_out <= dec.code;
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              exc_valid,
    input logic [CODE_W-1:0] exc_code,
    input logic              irq_req,
    input logic              in_sleep,
    input logic [XLEN-1:0]   sr_in,
    input logic              done,
    input logic [XLEN-1:0]   pc_out,
    input logic [XLEN-1:0]   sr_out,
    input logic [XLEN-1:0]   ssr_out,
    input logic [XLEN-1:0]   spc_out,
    input logic [CODE_W-1:0] expevt_out,
    input logic [CODE_W-1:0] intevt_out
);
    AST_EXC_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> done); // R1
    AST_BLOCK_TO_RESET: assert property (@(posedge clk) disable iff (rst)
        exc_valid && sr_in[SR_BL] && exc_code != C_UBREAK |=>
        expevt_out == C_RESET && pc_out == 32'hA000_0000 && sr_out[SR_IM +: MASK_W] == 4'hF && !sr_out[SR_FD]); // R2
    AST_BLOCKED_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        irq_req && !exc_valid && sr_in[SR_BL] && !in_sleep |=> !done); // R3
    AST_ENTRY_MODE_BITS: assert property (@(posedge clk) disable iff (rst)
        done |-> sr_out[SR_BL] && sr_out[SR_MD] && sr_out[SR_RB]); // R4
    AST_IDLE_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
        !exc_valid && !irq_req |=> !done); // R11
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(pc_out) && $stable(ssr_out) && $stable(spc_out)
                  && $stable(expevt_out) && $stable(intevt_out)); // R10
endmodule

bind exc_entry_top exc_entry_chk u_chk (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_code(exc_code),
    .irq_req(irq_req), .in_sleep(in_sleep), .sr_in(sr_in), .done(done),
    .pc_out(pc_out), .sr_out(sr_out), .ssr_out(ssr_out), .spc_out(spc_out),
    .expevt_out(expevt_out), .intevt_out(intevt_out)
);

// File: tb/tb_exc_entry_top.sv
module tb_exc_entry_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_valid = 1'b0, irq_req = 1'b0, in_sleep = 1'b0, in_dslot = 1'b0;
    logic [11:0] exc_code = '0, irq_vec = '0;
    logic        irq_vec_valid = 1'b0;
    logic [31:0] sr_in = '0, pc_in = '0, r15_in = '0, vbr_in = '0;
    logic [3:0]  irq_level;
    logic        done;
    logic [31:0] pc_out, sr_out, ssr_out, spc_out, sgr_out;
    logic [11:0] expevt_out, intevt_out;
    int checks = 0, fails = 0;

    localparam logic [31:0] VBR = 32'h8C00_0000;

    always #5 clk = ~clk;

    exc_entry_top dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one event for one cycle, then sample registered outputs.
    task automatic fire(logic e, logic [11:0] code, logic i, logic [31:0] sr,
                        logic [31:0] pc, logic ds);
        @(negedge clk);
        exc_valid = e; exc_code = code; irq_req = i; sr_in = sr; pc_in = pc;
        in_dslot = ds; r15_in = pc ^ 32'h5A5A_0000; vbr_in = VBR;
        @(negedge clk);
        exc_valid = 1'b0; irq_req = 1'b0; in_dslot = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 reset done", {31'b0, done}, 0);
        chk("R10 reset pc", pc_out, 0);
        chk("R10 reset expevt", {20'b0, expevt_out}, 0);
    endtask

    task automatic t_general;
        fire(1, 12'h180, 0, 32'h0000_0030, 32'h0000_1000, 0);
        chk("R8 general pc", pc_out, VBR + 32'h100);
        chk("R8 expevt", {20'b0, expevt_out}, 32'h180);
        chk("R4 ssr", ssr_out, 32'h0000_0030);
        chk("R4 spc", spc_out, 32'h0000_1000);
        chk("R4 sgr", sgr_out, 32'h5A5A_1000);
        chk("R4 sr", sr_out, 32'h7000_0030);
        chk("R10 done high", {31'b0, done}, 1);
        @(negedge clk);
        chk("R10 done one cycle", {31'b0, done}, 0);
    endtask

    task automatic t_tlb;
        fire(1, 12'h040, 0, 0, 32'h0000_2000, 0);
        chk("R7 tlb read pc", pc_out, VBR + 32'h400);
        fire(1, 12'h060, 0, 0, 32'h0000_2000, 0);
        chk("R7 tlb write pc", pc_out, VBR + 32'h400);
        chk("R8 expevt 060", {20'b0, expevt_out}, 32'h060);
    endtask

    task automatic t_trap_dslot;
        fire(1, 12'h160, 0, 0, 32'h0000_2000, 0);
        chk("R8 trap spc", spc_out, 32'h0000_2002);
        chk("R8 trap pc", pc_out, VBR + 32'h100);
        fire(1, 12'h180, 0, 0, 32'h0000_3000, 1);
        chk("R5 dslot spc", spc_out, 32'h0000_2FFE);
        fire(1, 12'h160, 0, 0, 32'h0000_3000, 1);
        chk("R5 R8 trap in dslot spc", spc_out, 32'h0000_3000);
    endtask

    task automatic t_reset_class;
        fire(1, 12'h140, 0, 32'h0000_8030, 32'h0000_4000, 0);
        chk("R6 pc", pc_out, 32'hA000_0000);
        chk("R6 sr", sr_out, 32'h7000_00F0);
        fire(1, 12'h020, 0, 32'h0000_8000, 32'h0000_4000, 0);
        chk("R6 manual pc", pc_out, 32'hA000_0000);
    endtask

    task automatic t_block;
        fire(1, 12'h180, 0, 32'h1000_0000, 32'h0000_5000, 0);
        chk("R2 converted code", {20'b0, expevt_out}, 0);
        chk("R2 converted pc", pc_out, 32'hA000_0000);
        chk("R2 converted sr", sr_out, 32'h7000_00F0);
        fire(1, 12'h1E0, 0, 32'h1000_0000, 32'h0000_5000, 0);
        chk("R2 passthrough code", {20'b0, expevt_out}, 32'h1E0);
        chk("R2 passthrough pc", pc_out, VBR + 32'h100);
    endtask

    task automatic t_irq;
        irq_vec_valid = 1'b1; irq_vec = 12'h3C0;
        sr_in = 32'h0000_0050; #1;
        chk("R9 mask level", {28'b0, irq_level}, 5);
        fire(0, 0, 1, 32'h0000_0050, 32'h0000_6000, 0);
        chk("R9 intevt", {20'b0, intevt_out}, 32'h3C0);
        chk("R9 pc", pc_out, VBR + 32'h600);
        chk("R9 expevt kept", {20'b0, expevt_out}, 32'h1E0);
        irq_vec_valid = 1'b0; irq_vec = 12'h200;
        fire(0, 0, 1, 32'h0000_0050, 32'h0000_7000, 0);
        chk("R9 no vector done", {31'b0, done}, 0);
        chk("R9 no vector pc", spc_out, 32'h0000_6000);
        chk("R9 no vector intevt", {20'b0, intevt_out}, 32'h3C0);
    endtask

    task automatic t_irq_block;
        irq_vec_valid = 1'b1; irq_vec = 12'h400;
        fire(0, 0, 1, 32'h1000_0000, 32'h0000_8000, 0);
        chk("R3 blocked done", {31'b0, done}, 0);
        chk("R3 blocked intevt", {20'b0, intevt_out}, 32'h3C0);
        in_sleep = 1'b1;
        fire(0, 0, 1, 32'h1000_0000, 32'h0000_8000, 0);
        in_sleep = 1'b0;
        chk("R3 sleep taken intevt", {20'b0, intevt_out}, 32'h400);
        chk("R3 sleep taken spc", spc_out, 32'h0000_8000);
    endtask

    task automatic t_priority;
        irq_vec = 12'h420;
        fire(1, 12'h0E0, 1, 0, 32'h0000_9000, 0);
        chk("R1 expevt", {20'b0, expevt_out}, 32'h0E0);
        chk("R1 intevt kept", {20'b0, intevt_out}, 32'h400);
        chk("R1 pc", pc_out, VBR + 32'h100);
        irq_vec_valid = 1'b0;
    endtask

    task automatic t_idle;
        fire(0, 0, 0, 32'h0000_00F0, 32'h0000_A000, 1);
        chk("R11 done", {31'b0, done}, 0);
        chk("R11 spc", spc_out, 32'h0000_9000);
        chk("R11 ssr", ssr_out, 0);
        chk("R11 expevt", {20'b0, expevt_out}, 32'h0E0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_general;
        t_tlb;
        t_trap_dslot;
        t_reset_class;
        t_block;
        t_irq;
        t_irq_block;
        t_priority;
        t_idle;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule